// File: doc/BRIEF.md
# SPI Register Slave with Status Byte

This block lets an external SPI master reach a bank of 32 byte-wide registers. Each transaction opens with a command byte. That byte holds a direction flag, a 5-bit register index and a burst flag. While the command byte shifts in, the slave shifts out a status byte. The status byte is a snapshot of eight flags supplied by the rest of the chip.

A write is a command byte followed by a single data byte. While the data byte is clocked in, the slave returns the register named by an internal echo pointer. The pointer resets to index 0, where the interrupt-status register sits. The write is held back until chip select rises. It is applied only if the frame held exactly sixteen clocks. Any other frame length drops the write.

A read returns the addressed register in the byte after the command. With the burst flag set, each following byte returns the next register. The block runs from a fast system clock. It treats SCLK, chip select and MOSI as already synchronised, and finds their edges by oversampling.

Top module: `spi_reg_slave`

## Requirements
- R1: The command byte carries the direction in bit 7 (1 = read, 0 = write), the register index in bits 6:2 and the burst flag in bit 0. Bit 1 is ignored. A read frame never produces a commit.
- R2: In the first byte of every frame, MISO returns `status_flags`, MSB first. The flags are sampled when chip select falls. Bit order, from bit 7 down to bit 0: access signal, converter ready, converter compare, bridge overcurrent, high-side overcurrent, motor current limit, SPI error, LIN interrupt.
- R3: SPI mode 0 applies. MOSI is sampled on rising SCLK edges and MISO changes only after falling SCLK edges, most significant bit first. MISO holds steady across each rising edge.
- R4: `miso_oe` is low whenever chip select has been high for a full clock, including after reset. It is high during a frame.
- R5: A write frame of exactly 16 SCLK rising edges raises `commit_valid` for exactly one cycle, one clock after chip select rises. `commit_addr` and `commit_data` carry the index and data byte, and the register takes the new value.
- R6: A write frame of fewer than 16 or more than 16 SCLK rising edges gives no commit pulse and leaves the register unchanged.
- R7: During the second byte of a write, MISO returns the register selected by the echo pointer. After reset the pointer selects index 0.
- R8: Register index 31 is the echo pointer. A write there sets the pointer to the low 5 data bits. A read there returns the pointer zero-extended to 8 bits.
- R9: A read with burst flag 0 returns the addressed register in the second byte. Every further byte repeats that same register.
- R10: A read with burst flag 1 returns consecutive registers, one per byte, starting at the addressed index. The index wraps from 31 to 0.
- R11: In a write frame the burst flag has no effect. A 16-clock write with burst set commits like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| status_flags | input | 8 | Flags returned as the status byte |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| commit_valid | output | 1 | One-cycle pulse when a write is applied |
| commit_addr | output | 5 | Register index of the applied write |
| commit_data | output | 8 | Data byte of the applied write |

## Verification
A bit or byte counter that is out by one shows up at the ports in one of three ways. A correct-length write stops committing, a 15-, 17- or 24-clock write starts committing, or a returned byte appears shifted by one bit position. Each of these is visible by the end of the frame it happened in. A wrong echo pointer, a missed wrap or a stale read index corrupts the very next returned byte. A lost commit shows up at the next read of that register, and the bench compares every returned byte against its own register model.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
  // Command byte field positions
  localparam int CMD_DIR_BIT   = 7;
  localparam int CMD_IDX_LSB   = 2;
  localparam int CMD_BURST_BIT = 0;

  // Completed bytes in the current frame (saturates at BYTES_MANY)
  typedef enum logic [1:0] {
    BYTES_NONE = 2'd0,
    BYTES_ONE  = 2'd1,
    BYTES_TWO  = 2'd2,
    BYTES_MANY = 2'd3
  } byte_cnt_e;
endpackage

// File: rtl/spi_rs_regfile.sv
module spi_rs_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PTR_INDEX = '1,
  parameter logic [ADDR_W-1:0] PTR_INIT  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_byte,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [ADDR_W-1:0] echo_ptr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              rd_hits_ptr;

  // Plain synchronous-read memory, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_byte;
    rd_q <= store[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      echo_ptr    <= PTR_INIT;
      rd_hits_ptr <= 1'b0;
    end else begin
      rd_hits_ptr <= (rd_idx == PTR_INDEX);
      if (wr_en && wr_idx == PTR_INDEX) echo_ptr <= wr_byte[ADDR_W-1:0];
    end
  end

  assign rd_byte = rd_hits_ptr ? {{(DATA_W-ADDR_W){1'b0}}, echo_ptr} : rd_q;

  // R8: the pointer moves only through a committed write to its own index
  assert_ptr_write_only_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(echo_ptr) |-> ($past(wr_en) && $past(wr_idx) == PTR_INDEX));
endmodule

// File: rtl/spi_rs_frame.sv
module spi_rs_frame #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0] rd_byte,
  input  logic [ADDR_W-1:0] echo_ptr,
  output logic [ADDR_W-1:0] rd_idx,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_idx,
  output logic [DATA_W-1:0] wr_byte,
  output logic              miso,
  output logic              miso_oe
);
  import spi_rs_pkg::*;

  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              sclk_q, cs_q;
  logic [BIT_W-1:0]  bit_pos;
  byte_cnt_e         nbytes;
  logic [DATA_W-1:0] rx_sh, cmd_q, data_q, tx_sh;

  logic              sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [DATA_W-1:0] rx_next;
  logic              burst_rd;

  assign sclk_rise = sclk & ~sclk_q & ~cs_n;
  assign sclk_fall = ~sclk & sclk_q & ~cs_n;
  assign cs_fall   = ~cs_n & cs_q;
  assign cs_rise   = cs_n & ~cs_q;
  assign rx_next   = {rx_sh[DATA_W-2:0], mosi};
  assign burst_rd  = cmd_q[CMD_DIR_BIT] & cmd_q[CMD_BURST_BIT];
  assign miso      = tx_sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      bit_pos <= '0;
      nbytes  <= BYTES_NONE;
      rx_sh   <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      tx_sh   <= '0;
      rd_idx  <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_byte <= '0;
      miso_oe <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      cs_q    <= cs_n;
      miso_oe <= ~cs_n;
      wr_en   <= 1'b0;

      if (cs_fall) begin
        bit_pos <= '0;
        nbytes  <= BYTES_NONE;
        cmd_q   <= '0;
        tx_sh   <= status_in;
      end else begin
        if (sclk_rise) begin
          rx_sh <= rx_next;
          if (bit_pos == LAST_BIT) begin
            bit_pos <= '0;
            if (nbytes != BYTES_MANY) nbytes <= byte_cnt_e'(nbytes + 2'd1);
            case (nbytes)
              BYTES_NONE: begin
                cmd_q  <= rx_next;
                rd_idx <= rx_next[CMD_DIR_BIT] ? rx_next[CMD_IDX_LSB +: ADDR_W] : echo_ptr;
              end
              BYTES_ONE: begin
                data_q <= rx_next;
                if (burst_rd) rd_idx <= rd_idx + 1'b1;
              end
              default: if (burst_rd) rd_idx <= rd_idx + 1'b1;
            endcase
          end else begin
            bit_pos <= bit_pos + 1'b1;
          end
        end
        if (sclk_fall) begin
          if (bit_pos == '0 && nbytes != BYTES_NONE) tx_sh <= rd_byte;
          else tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end

      if (cs_rise) begin
        wr_en   <= (nbytes == BYTES_TWO) && (bit_pos == '0) && !cmd_q[CMD_DIR_BIT];
        wr_idx  <= cmd_q[CMD_IDX_LSB +: ADDR_W];
        wr_byte <= data_q;
      end
    end
  end

  // R3: the transmit register moves only after a falling SCLK edge or a frame start
  assert_tx_moves_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_sh) |-> $past(sclk_fall || cs_fall));

  // R6: a frame that has run past two bytes can never yield a commit
  assert_long_frame_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && nbytes == BYTES_MANY) |=> !wr_en);
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PTR_INDEX = '1,
  parameter logic [ADDR_W-1:0] PTR_INIT  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [DATA_W-1:0] status_flags,
  output logic              miso,
  output logic              miso_oe,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  logic [ADDR_W-1:0] rd_idx;
  logic [DATA_W-1:0] rd_byte;
  logic [ADDR_W-1:0] echo_ptr;

  spi_rs_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .status_in(status_flags),
    .rd_byte  (rd_byte),
    .echo_ptr (echo_ptr),
    .rd_idx   (rd_idx),
    .wr_en    (commit_valid),
    .wr_idx   (commit_addr),
    .wr_byte  (commit_data),
    .miso     (miso),
    .miso_oe  (miso_oe)
  );

  spi_rs_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_INDEX(PTR_INDEX), .PTR_INIT(PTR_INIT)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (rd_idx),
    .rd_byte (rd_byte),
    .wr_en   (commit_valid),
    .wr_idx  (commit_addr),
    .wr_byte (commit_data),
    .echo_ptr(echo_ptr)
  );

  // R4: pad driver off once chip select has been high for a full clock
  assert_oe_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> !miso_oe);

  // R5: a commit follows a chip-select rising edge
  assert_commit_after_rise_R5: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> ($past(cs_n) && !$past(cs_n, 2)));

  // R5: commit pulse lasts one cycle
  assert_commit_single_R5: assert property (@(posedge clk) disable iff (rst)
    commit_valid |=> !commit_valid);
endmodule

// File: tb/spi_reg_slave_bench.sv
module spi_reg_slave_bench;
  logic       clk = 1'b0;
  logic       rst, sclk, cs_n, mosi;
  logic [7:0] status_flags;
  logic       miso, miso_oe, commit_valid;
  logic [4:0] commit_addr;
  logic [7:0] commit_data;

  always #5 clk = ~clk;

  spi_reg_slave u_spi_reg_slave (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .status_flags(status_flags), .miso(miso), .miso_oe(miso_oe),
    .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] tx_buf [0:7];
  logic [7:0] rx_buf [0:7];
  logic [7:0] model_mem [0:31];
  bit         known [0:31];
  logic [4:0] model_ptr;
  int         r3_bad;
  bit         oe_seen, commit_seen, commit_twice;
  logic [4:0] seen_addr;
  logic [7:0] seen_data;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input logic [4:0] a);
    return (a == 5'd31) ? {3'b000, model_ptr} : model_mem[a];
  endfunction

  function automatic bit reg_known(input logic [4:0] a);
    return (a == 5'd31) || known[a];
  endfunction

  task automatic xfer(input int nbits, input logic [7:0] flags);
    logic pre;
    r3_bad = 0;
    @(negedge clk);
    status_flags = flags;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    oe_seen = miso_oe;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx_buf[i/8][7-(i%8)];
      repeat (3) @(negedge clk);
      pre = miso;
      rx_buf[i/8][7-(i%8)] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      if (miso !== pre) r3_bad++;
      sclk = 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    commit_seen = commit_valid;
    seen_addr = commit_addr;
    seen_data = commit_data;
    @(negedge clk);
    commit_twice = commit_valid;
    mosi = 1'b0;
    chk(r3_bad == 0, "R3 miso steady across rising edges", r3_bad, 0);
    chk(oe_seen == 1'b1, "R4 oe high in frame", oe_seen, 1);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] d, input bit burst,
                          input int nbits, input string tag);
    logic [7:0] fl = 8'($urandom);
    logic [4:0] ptr_before = model_ptr;
    tx_buf[0] = {1'b0, a, 1'b0, burst};
    tx_buf[1] = d;
    tx_buf[2] = 8'($urandom);
    xfer(nbits, fl);
    chk(rx_buf[0] == fl, "R2 status byte", rx_buf[0], fl);
    if (nbits >= 16 && reg_known(ptr_before))
      chk(rx_buf[1] == exp_reg(ptr_before), "R7 echo byte", rx_buf[1], exp_reg(ptr_before));
    if (nbits == 16) begin
      chk(commit_seen && seen_addr == a && seen_data == d, tag,
          {commit_seen, 3'b0, seen_addr, seen_data}, {1'b1, 3'b0, a, d});
      chk(!commit_twice, "R5 single pulse", commit_twice, 0);
      model_mem[a] = d;
      known[a] = 1;
      if (a == 5'd31) model_ptr = d[4:0];
    end else begin
      chk(!commit_seen, "R6 wrong length dropped", commit_seen, 0);
    end
  endtask

  task automatic do_read(input logic [4:0] a, input bit burst, input int nb);
    logic [7:0] fl = 8'($urandom);
    logic [4:0] idx;
    tx_buf[0] = {1'b1, a, 1'b0, burst};
    for (int k = 1; k < 8; k++) tx_buf[k] = 8'($urandom);
    xfer(nb * 8, fl);
    chk(rx_buf[0] == fl, "R2 status byte", rx_buf[0], fl);
    chk(!commit_seen, "R1 read never commits", commit_seen, 0);
    for (int k = 1; k < nb; k++) begin
      idx = burst ? 5'(a + k - 1) : a;
      if (reg_known(idx)) begin
        if (burst) chk(rx_buf[k] == exp_reg(idx), "R10 burst byte", rx_buf[k], exp_reg(idx));
        else       chk(rx_buf[k] == exp_reg(idx), "R9 single read byte", rx_buf[k], exp_reg(idx));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] old5;
    void'($urandom(32'd4242));
    rst = 1'b1; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; status_flags = '0;
    model_ptr = 5'd0;
    for (int i = 0; i < 32; i++) begin known[i] = 0; model_mem[i] = '0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(miso_oe == 1'b0, "R4 oe low after reset", miso_oe, 0);
    chk(commit_valid == 1'b0, "R5 no commit after reset", commit_valid, 0);

    // Fill registers 0..30; echoes from write 1 on use the reset pointer (R7)
    for (int a = 0; a < 31; a++) do_write(5'(a), 8'($urandom), 1'b0, 16, "R5 commit");

    // R6: 17, 24 and 15 clock writes dropped, register unchanged
    old5 = model_mem[5];
    do_write(5'd5, ~old5, 1'b0, 17, "R6");
    do_write(5'd5, ~old5, 1'b0, 24, "R6");
    do_write(5'd5, ~old5, 1'b0, 15, "R6");
    do_read(5'd5, 1'b0, 2);
    chk(rx_buf[1] == old5, "R6 register unchanged", rx_buf[1], old5);

    // R11: burst flag ignored on write
    do_write(5'd7, 8'h3C, 1'b1, 16, "R11 burst write commits");
    do_read(5'd7, 1'b0, 2);

    // R8: pointer register
    do_write(5'd31, 8'hE5, 1'b0, 16, "R8 pointer write");
    do_read(5'd31, 1'b0, 2);
    chk(rx_buf[1] == 8'h05, "R8 pointer readback", rx_buf[1], 8'h05);
    do_write(5'd2, 8'h99, 1'b0, 16, "R5 commit");
    chk(rx_buf[1] == model_mem[5], "R8 echo follows pointer", rx_buf[1], model_mem[5]);

    // R10: burst wraps 29,30,31,0,1 ; R9: single read repeats
    do_read(5'd29, 1'b1, 6);
    do_read(5'd12, 1'b0, 4);

    // Random mix
    for (int n = 0; n < 120; n++) begin
      case ($urandom % 4)
        0: do_write(5'($urandom), 8'($urandom), 1'($urandom), 16, "R5 commit");
        1: do_read(5'($urandom), 1'b0, 2 + ($urandom % 2));
        2: do_read(5'($urandom), 1'b1, 2 + ($urandom % 5));
        default: do_write(5'($urandom), 8'($urandom), 1'b0,
                          ($urandom % 2) ? 9 + ($urandom % 7) : 17 + ($urandom % 16), "R6");
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule